// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block connects a simple synchronous host port to a DRAM device whose storage is a square array of 2048 rows by 2048 columns, four bits wide, addressed through only 11 shared address pins. The host offers a 22-bit word address, a direction bit and four bits of write data under a valid/ready handshake. The controller places the row half of the address on the pins under an active-low row strobe. It then places the column half under an active-low column strobe. It drives active-low write-enable and output-enable and hands read data back with a one-cycle valid pulse. A write finishes with a one-cycle acknowledge.

Stored charge leaks, so an interval timer raises a refresh request at a fixed period whether or not the host is busy. Each refresh strobes one row with the column strobe held high. The row comes from a counter that walks through every row. A pending refresh is taken before any new host request but never cuts into an access already under way. Every access and every refresh ends with a precharge interval during which both strobes stay high, which lets a row disturbed by a destructive read be restored before the next cycle.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While reset is held and right after its release, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, `rsp_valid`, `wr_ack` and `dram_dq_oe` are 0, and `req_ready` is 1.
- R2: For an accepted request, the pins carry `req_addr[21:11]` while the row strobe falls and `req_addr[10:0]` during the column phase.
- R3: The row strobe is low for at least RAS_TO_CAS cycles before the column strobe falls, and the column strobe is low only while the row strobe is low.
- R4: A read holds `dram_oe_n` low and `dram_we_n` high through a column phase of CAS_CYCLES cycles. It samples `dram_dq_in` at the end of that phase and returns the value on `rsp_rdata` with `rsp_valid` high for exactly one cycle. A read returns the last value written to that address.
- R5: A write holds `dram_we_n` low and `dram_dq_oe` high with the data on `dram_dq_out` through the column phase, then pulses `wr_ack` for one cycle. `dram_dq_oe` is never high outside a write column phase.
- R6: Between two row-strobe low periods, the row strobe (and so the column strobe) stays high for at least PRECHARGE cycles.
- R7: A refresh is a row-strobe low period with the column strobe high throughout. It runs even with no host traffic. Rows are refreshed in the order 0, 1, 2, … and wrap from 2047 back to 0.
- R8: A refresh request is served before a waiting host request. An access in progress is never interrupted. The distance between successive refresh starts stays within REFRESH_INTERVAL ± (RAS_TO_CAS + CAS_CYCLES + PRECHARGE + 3) cycles under continuous host traffic.
- R9: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 whenever the row strobe is low. Each accepted read gets exactly one `rsp_valid` and each accepted write exactly one `wr_ack`, never both in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address: row in [21:11], column in [10:0] |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 4 | Read data |
| wr_ack | output | 1 | One-cycle pulse: write finished |
| dram_addr | output | 11 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data toward the device |
| dram_dq_oe | output | 1 | Controller drives the data lines |
| dram_dq_in | input | 4 | Data from the device |

## Verification
Directed writes and reads first cover the address corners: all zeros, all ones, a step of one row with column zero, and the last column of row zero. Alternating-bit patterns follow. Together these separate a swapped or shifted row/column split from a correct one, and reading an unwritten word shows that only the addressed cell answers. A long run of back-to-back mixed accesses on a small address set that spans several rows and columns then checks read-after-write and overwrite ordering while refresh requests keep landing in the middle of accesses. That run shows whether refresh waits for the current access and still keeps its period. A final idle stretch long enough to cover every row confirms that refresh continues without traffic and that the row counter wraps.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_COL,
      ST_PRE,
      ST_REF
   } dmc_state_e;
endpackage

// File: rtl/dmc_addr_split.sv
// Splits a flat word address into row and column halves sized to the pins.
module dmc_addr_split #(
   parameter int ROW_W = 11,
   parameter int COL_W = 11,
   parameter int PIN_W = 11
) (
   input  logic [ROW_W+COL_W-1:0] addr,
   output logic [PIN_W-1:0]       row_pins,
   output logic [PIN_W-1:0]       col_pins
);
   localparam int ADDR_W = ROW_W + COL_W;

   if (PIN_W < ROW_W || PIN_W < COL_W) begin : g_bad_pins
      $error("PIN_W must cover both address halves");
   end

   if (PIN_W == ROW_W) begin : g_row_full
      assign row_pins = addr[ADDR_W-1:COL_W];
   end else begin : g_row_pad
      assign row_pins = {{(PIN_W-ROW_W){1'b0}}, addr[ADDR_W-1:COL_W]};
   end

   if (PIN_W == COL_W) begin : g_col_full
      assign col_pins = addr[COL_W-1:0];
   end else begin : g_col_pad
      assign col_pins = {{(PIN_W-COL_W){1'b0}}, addr[COL_W-1:0]};
   end
endmodule

// File: rtl/dmc_refresh_timer.sv
// Interval timer raising a sticky refresh request and holding the next row.
module dmc_refresh_timer #(
   parameter int INTERVAL = 390,
   parameter int ROW_W    = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_grant,
   output logic             ref_pending,
   output logic [ROW_W-1:0] ref_row
);
   localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

   if (INTERVAL < 2) begin : g_bad_interval
      $error("INTERVAL must be at least 2");
   end

   logic [CNT_W-1:0] tick_cnt_q;
   logic             tick;

   assign tick = (tick_cnt_q == CNT_W'(INTERVAL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_cnt_q  <= '0;
         ref_pending <= 1'b0;
         ref_row     <= '0;
      end else begin
         tick_cnt_q  <= tick ? '0 : tick_cnt_q + CNT_W'(1);
         ref_pending <= tick | (ref_pending & ~ref_grant);
         if (ref_grant) begin
            ref_row <= ref_row + ROW_W'(1);
         end
      end
   end
endmodule

// File: rtl/dmc_seq.sv
// Access / refresh sequencer driving the strobes and the multiplexed pins.
module dmc_seq
   import dmc_pkg::*;
#(
   parameter int PIN_W     = 11,
   parameter int DQ_W      = 4,
   parameter int T_RCD     = 2,
   parameter int T_CAS     = 2,
   parameter int T_REF     = 4,
   parameter int T_PRE     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [PIN_W-1:0] row_pins,
   input  logic [PIN_W-1:0] col_pins,
   input  logic [DQ_W-1:0]  req_wdata,
   input  logic             ref_pending,
   input  logic [PIN_W-1:0] ref_pins,
   input  logic [DQ_W-1:0]  dq_in,
   output logic             req_ready,
   output logic             ref_grant,
   output logic             rsp_valid,
   output logic [DQ_W-1:0]  rsp_rdata,
   output logic             wr_ack,
   output logic [PIN_W-1:0] pins,
   output logic             ras_n,
   output logic             cas_n,
   output logic             we_n,
   output logic             oe_n,
   output logic [DQ_W-1:0]  dq_out,
   output logic             dq_oe
);
   localparam int T_MAX1 = (T_RCD > T_CAS) ? T_RCD : T_CAS;
   localparam int T_MAX2 = (T_REF > T_PRE) ? T_REF : T_PRE;
   localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
   localparam int TMR_W  = $clog2(T_MAX + 1);

   localparam logic [TMR_W-1:0] LD_RCD = TMR_W'(T_RCD - 1);
   localparam logic [TMR_W-1:0] LD_CAS = TMR_W'(T_CAS - 1);
   localparam logic [TMR_W-1:0] LD_REF = TMR_W'(T_REF - 1);
   localparam logic [TMR_W-1:0] LD_PRE = TMR_W'(T_PRE - 1);

   dmc_state_e       state_q;
   logic [TMR_W-1:0] tmr_q;
   logic [PIN_W-1:0] pins_q;
   logic [PIN_W-1:0] col_q;
   logic             wr_q;
   logic [DQ_W-1:0]  wdata_q;
   logic [DQ_W-1:0]  rdata_q;
   logic             rvalid_q;
   logic             ack_q;
   logic             tmr_done;

   assign tmr_done = (tmr_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         tmr_q    <= '0;
         pins_q   <= '0;
         col_q    <= '0;
         wr_q     <= 1'b0;
         wdata_q  <= '0;
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
         ack_q    <= 1'b0;
      end else begin
         rvalid_q <= 1'b0;
         ack_q    <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (ref_pending) begin
                  state_q <= ST_REF;
                  tmr_q   <= LD_REF;
                  pins_q  <= ref_pins;
               end else if (req_valid) begin
                  state_q <= ST_ROW;
                  tmr_q   <= LD_RCD;
                  pins_q  <= row_pins;
                  col_q   <= col_pins;
                  wr_q    <= req_write;
                  wdata_q <= req_wdata;
               end
            end
            ST_ROW: begin
               if (tmr_done) begin
                  state_q <= ST_COL;
                  tmr_q   <= LD_CAS;
                  pins_q  <= col_q;
               end else begin
                  tmr_q <= tmr_q - TMR_W'(1);
               end
            end
            ST_COL: begin
               if (tmr_done) begin
                  state_q <= ST_PRE;
                  tmr_q   <= LD_PRE;
                  if (wr_q) begin
                     ack_q <= 1'b1;
                  end else begin
                     rdata_q  <= dq_in;
                     rvalid_q <= 1'b1;
                  end
               end else begin
                  tmr_q <= tmr_q - TMR_W'(1);
               end
            end
            ST_REF: begin
               if (tmr_done) begin
                  state_q <= ST_PRE;
                  tmr_q   <= LD_PRE;
               end else begin
                  tmr_q <= tmr_q - TMR_W'(1);
               end
            end
            ST_PRE: begin
               if (tmr_done) begin
                  state_q <= ST_IDLE;
               end else begin
                  tmr_q <= tmr_q - TMR_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE) && !ref_pending;
   assign ref_grant = (state_q == ST_IDLE) && ref_pending;
   assign rsp_valid = rvalid_q;
   assign rsp_rdata = rdata_q;
   assign wr_ack    = ack_q;
   assign pins      = pins_q;
   assign ras_n     = !((state_q == ST_ROW) || (state_q == ST_COL) || (state_q == ST_REF));
   assign cas_n     = !(state_q == ST_COL);
   assign we_n      = !((state_q == ST_COL) && wr_q);
   assign oe_n      = !((state_q == ST_COL) && !wr_q);
   assign dq_oe     = (state_q == ST_COL) && wr_q;
   assign dq_out    = wdata_q;
endmodule

// File: rtl/dram_mux_ctrl.sv
// Top: host port to multiplexed-address DRAM with interleaved refresh.
module dram_mux_ctrl #(
   parameter int ROW_W            = 11,
   parameter int COL_W            = 11,
   parameter int DQ_W             = 4,
   parameter int REFRESH_INTERVAL = 390,
   parameter int RAS_TO_CAS       = 2,
   parameter int CAS_CYCLES       = 2,
   parameter int REFRESH_RAS      = 4,
   parameter int PRECHARGE        = 3,
   localparam int ADDR_W          = ROW_W + COL_W,
   localparam int PIN_W           = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DQ_W-1:0]   req_wdata,
   output logic              rsp_valid,
   output logic [DQ_W-1:0]   rsp_rdata,
   output logic              wr_ack,
   output logic [PIN_W-1:0]  dram_addr,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [DQ_W-1:0]   dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DQ_W-1:0]   dram_dq_in
);
   localparam int ACCESS_SPAN = RAS_TO_CAS + CAS_CYCLES + PRECHARGE + 1;
   localparam int REFRESH_SPAN = REFRESH_RAS + PRECHARGE + 1;

   if (RAS_TO_CAS < 1 || CAS_CYCLES < 1 || REFRESH_RAS < 1 || PRECHARGE < 1) begin : g_bad_timing
      $error("all timing parameters must be at least 1");
   end
   if (REFRESH_INTERVAL <= ACCESS_SPAN + REFRESH_SPAN) begin : g_bad_interval
      $error("REFRESH_INTERVAL too short to fit one access and one refresh");
   end
   if (DQ_W < 1) begin : g_bad_dq
      $error("DQ_W must be at least 1");
   end

   logic [PIN_W-1:0] row_pins;
   logic [PIN_W-1:0] col_pins;
   logic             ref_pending;
   logic             ref_grant;
   logic [ROW_W-1:0] ref_row;
   logic [PIN_W-1:0] ref_pins;

   assign ref_pins = PIN_W'(ref_row);

   dmc_addr_split #(
      .ROW_W (ROW_W),
      .COL_W (COL_W),
      .PIN_W (PIN_W)
   ) u_split (
      .addr     (req_addr),
      .row_pins (row_pins),
      .col_pins (col_pins)
   );

   dmc_refresh_timer #(
      .INTERVAL (REFRESH_INTERVAL),
      .ROW_W    (ROW_W)
   ) u_refresh (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_grant   (ref_grant),
      .ref_pending (ref_pending),
      .ref_row     (ref_row)
   );

   dmc_seq #(
      .PIN_W (PIN_W),
      .DQ_W  (DQ_W),
      .T_RCD (RAS_TO_CAS),
      .T_CAS (CAS_CYCLES),
      .T_REF (REFRESH_RAS),
      .T_PRE (PRECHARGE)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .row_pins    (row_pins),
      .col_pins    (col_pins),
      .req_wdata   (req_wdata),
      .ref_pending (ref_pending),
      .ref_pins    (ref_pins),
      .dq_in       (dram_dq_in),
      .req_ready   (req_ready),
      .ref_grant   (ref_grant),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata),
      .wr_ack      (wr_ack),
      .pins        (dram_addr),
      .ras_n       (dram_ras_n),
      .cas_n       (dram_cas_n),
      .we_n        (dram_we_n),
      .oe_n        (dram_oe_n),
      .dq_out      (dram_dq_out),
      .dq_oe       (dram_dq_oe)
   );
endmodule

// File: rtl/dmc_checker.sv
// Protocol checker bound to the controller top.
module dmc_checker #(
   parameter int PRECHARGE = 3
) (
   input logic clk,
   input logic rst_n,
   input logic dram_ras_n,
   input logic dram_cas_n,
   input logic dram_we_n,
   input logic dram_oe_n,
   input logic dram_dq_oe,
   input logic req_ready,
   input logic rsp_valid,
   input logic wr_ack
);
   localparam int HC_W = $clog2(PRECHARGE + 1) + 1;

   logic [HC_W-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= HC_W'(PRECHARGE);
      end else if (!dram_ras_n) begin
         hi_cnt <= '0;
      end else if (hi_cnt < HC_W'(PRECHARGE)) begin
         hi_cnt <= hi_cnt + HC_W'(1);
      end
   end

   a_r3_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);

   a_r3_ras_leads_cas: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) |-> $past(!dram_ras_n));

   a_r6_precharge_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (hi_cnt >= HC_W'(PRECHARGE)));

   a_r4_oe_only_read_col: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_oe_n |-> (!dram_cas_n && dram_we_n));

   a_r5_dq_only_write: assert property (@(posedge clk) disable iff (!rst_n)
      dram_dq_oe |-> (!dram_we_n && !dram_cas_n));

   a_r9_one_kind_of_resp: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && wr_ack));

   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_ras_n |-> !req_ready);

   a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |=> !wr_ack);
endmodule

bind dram_mux_ctrl dmc_checker #(
   .PRECHARGE (PRECHARGE)
) u_dmc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .dram_ras_n (dram_ras_n),
   .dram_cas_n (dram_cas_n),
   .dram_we_n  (dram_we_n),
   .dram_oe_n  (dram_oe_n),
   .dram_dq_oe (dram_dq_oe),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .wr_ack     (wr_ack)
);

// File: tb/test_dram_mux_ctrl.sv
module test_dram_mux_ctrl;
   localparam int ROW_W   = 11;
   localparam int COL_W   = 11;
   localparam int DQ_W    = 4;
   localparam int ADDR_W  = ROW_W + COL_W;
   localparam int PIN_W   = 11;
   localparam int N_REF   = 40;
   localparam int RCD     = 2;
   localparam int CL      = 2;
   localparam int TRAS    = 4;
   localparam int PRE     = 3;
   localparam int NROWS   = 1 << ROW_W;
   localparam int SLACK   = RCD + CL + PRE + 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DQ_W-1:0]   req_wdata = '0;
   logic              rsp_valid;
   logic [DQ_W-1:0]   rsp_rdata;
   logic              wr_ack;
   logic [PIN_W-1:0]  dram_addr;
   logic              dram_ras_n;
   logic              dram_cas_n;
   logic              dram_we_n;
   logic              dram_oe_n;
   logic [DQ_W-1:0]   dram_dq_out;
   logic              dram_dq_oe;
   logic [DQ_W-1:0]   dram_dq_in = '0;

   dram_mux_ctrl #(
      .ROW_W            (ROW_W),
      .COL_W            (COL_W),
      .DQ_W             (DQ_W),
      .REFRESH_INTERVAL (N_REF),
      .RAS_TO_CAS       (RCD),
      .CAS_CYCLES       (CL),
      .REFRESH_RAS      (TRAS),
      .PRECHARGE        (PRE)
   ) i_dram_mux_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata),
      .wr_ack      (wr_ack),
      .dram_addr   (dram_addr),
      .dram_ras_n  (dram_ras_n),
      .dram_cas_n  (dram_cas_n),
      .dram_we_n   (dram_we_n),
      .dram_oe_n   (dram_oe_n),
      .dram_dq_out (dram_dq_out),
      .dram_dq_oe  (dram_dq_oe),
      .dram_dq_in  (dram_dq_in)
   );

   int checks = 0;
   int failures = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- device model ----------------
   logic [DQ_W-1:0]   mem [int];
   logic [PIN_W-1:0]  lat_row = '0;
   logic              ras_prev = 1'b1;
   logic              cas_prev = 1'b1;
   int                ras_lo_cnt = 0;
   int                ras_hi_cnt = 1000;
   bit                cas_seen = 1'b0;
   int                ref_cnt = 0;
   int                exp_ref_row = 0;
   longint            cyc = 0;
   longint            cur_fall = 0;
   longint            last_ref_fall = -1;
   logic [ADDR_W-1:0] cur_addr = '0;
   int                mkey;
   int                rkey;

   always @(posedge clk) begin
      cyc++;
      if (rst_n) begin
         if (!dram_ras_n && ras_prev) begin
            check(ras_hi_cnt >= PRE, "R6", "row strobe high time", ras_hi_cnt, PRE);
            lat_row    = dram_addr;
            cur_fall   = cyc;
            cas_seen   = 1'b0;
            ras_lo_cnt = 0;
         end
         if (!dram_ras_n) ras_lo_cnt++;
         if (!dram_cas_n && cas_prev) begin
            cas_seen = 1'b1;
            check(ras_lo_cnt > RCD, "R3", "row-to-column lead", ras_lo_cnt - 1, RCD);
            check({lat_row, dram_addr} == cur_addr, "R2", "row/column split",
                  {lat_row, dram_addr}, cur_addr);
         end
         if (!dram_cas_n && !dram_we_n) begin
            mkey = int'({lat_row, dram_addr});
            mem[mkey] = dram_dq_out;
         end
         if (dram_ras_n && !ras_prev && !cas_seen) begin
            check(lat_row == PIN_W'(exp_ref_row), "R7", "refresh row order", lat_row, exp_ref_row);
            if (ref_cnt == NROWS) begin
               check(lat_row == '0, "R7", "refresh row wrap", lat_row, 0);
            end
            if (last_ref_fall >= 0) begin
               check((cur_fall - last_ref_fall <= N_REF + SLACK) &&
                     (cur_fall - last_ref_fall >= N_REF - SLACK),
                     "R8", "refresh spacing", cur_fall - last_ref_fall, N_REF);
            end
            last_ref_fall = cur_fall;
            exp_ref_row   = (exp_ref_row + 1) % NROWS;
            ref_cnt++;
         end
         if (dram_ras_n) ras_hi_cnt++;
         else ras_hi_cnt = 0;
         ras_prev = dram_ras_n;
         cas_prev = dram_cas_n;
      end
   end

   always @(negedge clk) begin
      rkey = int'({lat_row, dram_addr});
      if (!dram_cas_n && !dram_oe_n)
         dram_dq_in <= mem.exists(rkey) ? mem[rkey] : '0;
      else
         dram_dq_in <= '0;
   end

   // ---------------- scoreboard ----------------
   logic [DQ_W-1:0] shadow [int];
   logic [DQ_W-1:0] exp_q [$];
   int writes_issued = 0;
   int acks_seen = 0;
   int reads_issued = 0;
   int reads_done = 0;

   task automatic host_op(input bit wr, input logic [ADDR_W-1:0] a, input logic [DQ_W-1:0] d);
      int k;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      forever begin
         @(posedge clk);
         if (req_ready) break;
      end
      cur_addr = a;
      k = int'(a);
      if (wr) begin
         shadow[k] = d;
         writes_issued++;
      end else begin
         exp_q.push_back(shadow.exists(k) ? shadow[k] : '0);
         reads_issued++;
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   logic [DQ_W-1:0] exp_v;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected read response", 1, 0);
            end else begin
               exp_v = exp_q.pop_front();
               check(rsp_rdata == exp_v, "R4", "read data", rsp_rdata, exp_v);
            end
            reads_done++;
         end
         if (wr_ack) acks_seen++;
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL R9 watchdog expired: actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

   initial begin
      logic [31:0] x;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(dram_ras_n && dram_cas_n, "R1", "strobes in reset", {dram_ras_n, dram_cas_n}, 3);
      check(dram_we_n && dram_oe_n, "R1", "enables in reset", {dram_we_n, dram_oe_n}, 3);
      check(!rsp_valid && !wr_ack && !dram_dq_oe, "R1", "pulses in reset",
            {rsp_valid, wr_ack, dram_dq_oe}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
      check(dram_ras_n && dram_cas_n, "R1", "strobes after reset", {dram_ras_n, dram_cas_n}, 3);

      // R2/R4/R5: address corners and patterns
      host_op(1'b1, 22'h000000, 4'h3);
      host_op(1'b1, 22'h3FFFFF, 4'hC);
      host_op(1'b1, 22'h000800, 4'h5);
      host_op(1'b1, 22'h0007FF, 4'hA);
      host_op(1'b1, 22'h155555, 4'h9);
      host_op(1'b1, 22'h2AAAAA, 4'h6);
      host_op(1'b0, 22'h000000, 4'h0);
      host_op(1'b0, 22'h3FFFFF, 4'h0);
      host_op(1'b0, 22'h000800, 4'h0);
      host_op(1'b0, 22'h0007FF, 4'h0);
      host_op(1'b0, 22'h155555, 4'h0);
      host_op(1'b0, 22'h2AAAAA, 4'h0);
      host_op(1'b0, 22'h000801, 4'h0);
      host_op(1'b1, 22'h155555, 4'hF);
      host_op(1'b0, 22'h155555, 4'h0);

      // R8: continuous mixed traffic with refresh interleaved
      x = 32'h1234_5678;
      for (int i = 0; i < 400; i++) begin
         x = x ^ (x << 13);
         x = x ^ (x >> 17);
         x = x ^ (x << 5);
         host_op(x[4], {x[3:2], 9'd0, x[1:0], 9'd5}, x[11:8]);
      end

      for (int i = 0; i < 200 && reads_done < reads_issued; i++) @(negedge clk);
      check(reads_done == reads_issued, "R9", "read responses", reads_done, reads_issued);
      check(acks_seen == writes_issued, "R5", "write acknowledges", acks_seen, writes_issued);
      check(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);

      // R7: idle refresh over every row and across the wrap
      while (ref_cnt < NROWS + 3) @(posedge clk);
      @(negedge clk);
      check(ref_cnt >= NROWS + 3, "R7", "idle refresh count", ref_cnt, NROWS + 3);
      check(!rsp_valid && !wr_ack, "R9", "no stray responses when idle", {rsp_valid, wr_ack}, 0);
      finish_run();
   end
endmodule